// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a synchronous on-chip requester reach an external asynchronous static RAM of 262,144 words by 16 bits. The RAM has one chip select and separate enables for the low and high byte. A request carries an 18-bit word address, a read/write flag, 16 bits of write data and a 2-bit lane mask. The controller latches the request and runs the RAM strobes through a fixed sequence whose lengths are whole clock cycles. It returns read data with a single-cycle valid pulse.

The request side is a valid/ready stream. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a requester that holds `req_valid` waits without losing its request. The response side takes no back-pressure. `rsp_valid` is a one-cycle pulse that the requester must take in that cycle. The memory data bus is split into `mem_dout` with its drive enable `mem_dout_en` and the returned `mem_din`. The pad ring combines them into the shared bidirectional pins.

Read access time equals cycle time. The access length is `ACC_CYC`, which is `T_ACCESS_NS` divided by `CLK_PERIOD_NS` and rounded up. With the defaults of 55 ns and 20 ns this gives 3 cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every cycle the controller is idle, the RAM is in standby. Chip select, write enable, output enable and both byte enables are high, `mem_dout_en` is low, `busy` is low and `req_ready` is high.
- R2: A request is taken on a clock edge with `req_valid` and `req_ready` high. `busy` is high from the next cycle until the controller is idle again. During that time `mem_addr` shows the accepted address and does not change.
- R3: Mask bit 0 selects data bits 7:0 and drives the low-byte enable low. Mask bit 1 selects bits 15:8 and drives the high-byte enable low. A request with mask 2'b00 is accepted and then dropped. It produces no strobe, no response, no busy cycle and no change to memory.
- R4: A read holds chip select and output enable low and write enable high for `ACC_CYC` cycles. It samples `mem_din` on the last of those cycles.
- R5: For a read, `rsp_valid` is high for exactly one cycle, `ACC_CYC`+1 cycles after the accepting edge. Lanes not selected by the mask read back as zero in `rsp_rdata`.
- R6: Before a write, output enable is high and `mem_dout_en` is low for `TURN_CYC` cycles while chip select is low. `mem_dout_en` is never high while output enable is low.
- R7: A write holds write enable low for `ACC_CYC` cycles while the data is driven. In the cycle after write enable rises, address, data, lane enables and drive enable are unchanged. The write then takes `TURN_CYC`+`ACC_CYC`+`REC_CYC` cycles in total.
- R8: A new request is accepted in the first cycle the controller is idle again, so a read can follow a write with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| busy | output | 1 | Access in progress |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_ub_n | output | 1 | RAM high-byte enable, active low |
| mem_lb_n | output | 1 | RAM low-byte enable, active low |
| mem_addr | output | 18 | RAM word address |
| mem_dout | output | 16 | Data toward the RAM |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Data from the RAM pins |

## Verification
The assertions check the bus-safety rules in every cycle. They cover standby while idle, no drive while output enable is low, the turnaround cycle before write enable falls, the hold of address and data across the rising edge of write enable, the single-cycle response pulse and the drop of empty-mask requests. The bench scenarios are needed to show that the right bytes land in memory and come back. A behavioural RAM model captures data on the write-enable rising edge. The bench also checks the response latency and the write-enable width in cycles, and that a read directly after a write returns the new data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_DONE    = 3'd2,
    ST_WR_TURN    = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5
  } seq_state_e;

  function automatic int cycles_for(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_mask,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_data,
  output logic [LANES-1:0]  held_mask
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_data <= '0;
      held_mask <= '0;
    end else if (load) begin
      held_addr <= in_addr;
      held_data <= in_data;
      held_mask <= in_mask;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int ACC_CYC  = 3,
  parameter int TURN_CYC = 1,
  parameter int REC_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_rd,
  input  logic       start_wr,
  output seq_state_e state,
  output logic       phase_last
);

  localparam int MAX_AT = (ACC_CYC > TURN_CYC) ? ACC_CYC : TURN_CYC;
  localparam int MAXC   = (MAX_AT > REC_CYC) ? MAX_AT : REC_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign phase_last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_rd) begin
            state <= ST_RD_ACCESS;
            cnt   <= CW'(ACC_CYC - 1);
          end else if (start_wr) begin
            state <= ST_WR_TURN;
            cnt   <= CW'(TURN_CYC - 1);
          end
        end
        ST_RD_ACCESS: begin
          if (phase_last) state <= ST_RD_DONE;
          else            cnt   <= cnt - 1'b1;
        end
        ST_RD_DONE: state <= ST_IDLE;
        ST_WR_TURN: begin
          if (phase_last) begin
            state <= ST_WR_PULSE;
            cnt   <= CW'(ACC_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WR_PULSE: begin
          if (phase_last) begin
            state <= ST_WR_RECOVER;
            cnt   <= CW'(REC_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WR_RECOVER: begin
          if (phase_last) state <= ST_IDLE;
          else            cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($past(state) != ST_RD_DONE || state == ST_IDLE));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] lane_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_data[g*LANE_W +: LANE_W] = mask[g] ? din[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= lane_data;
    end
  end

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ACCESS_NS   = 55,
  parameter int TURN_CYC      = 1,
  parameter int REC_CYC       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int LANES   = 2;
  localparam int ACC_CYC = cycles_for(T_ACCESS_NS, CLK_PERIOD_NS);

  seq_state_e        state;
  logic              phase_last;
  logic              accept;
  logic              start_rd;
  logic              start_wr;
  logic              in_access;
  logic [LANES-1:0]  held_mask;
  logic [LANES-1:0]  be_n;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_data;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign start_rd  = accept && !req_write && (req_mask != '0);
  assign start_wr  = accept &&  req_write && (req_mask != '0);

  sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_addr(req_addr), .in_data(req_wdata), .in_mask(req_mask),
    .held_addr(held_addr), .held_data(held_data), .held_mask(held_mask)
  );

  sram_seq_fsm #(.ACC_CYC(ACC_CYC), .TURN_CYC(TURN_CYC), .REC_CYC(REC_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
    .state(state), .phase_last(phase_last)
  );

  sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .capture(state == ST_RD_ACCESS && phase_last),
    .mask(held_mask), .din(mem_din),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign in_access = (state == ST_RD_ACCESS) || (state == ST_WR_TURN) ||
                     (state == ST_WR_PULSE)  || (state == ST_WR_RECOVER);

  for (genvar g = 0; g < LANES; g++) begin : g_be
    assign be_n[g] = !(in_access && held_mask[g]);
  end

  assign mem_cs_n    = !in_access;
  assign mem_oe_n    = (state != ST_RD_ACCESS);
  assign mem_we_n    = (state != ST_WR_PULSE);
  assign mem_lb_n    = be_n[0];
  assign mem_ub_n    = be_n[1];
  assign mem_addr    = held_addr;
  assign mem_dout    = held_data;
  assign mem_dout_en = (state == ST_WR_PULSE) || (state == ST_WR_RECOVER);

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dout_en));

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

  assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == 2'b00) |=> !busy);

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dout_en && !mem_oe_n));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_dout_en) && !$past(mem_cs_n)));

  assert_we_rise_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> (mem_dout_en && !mem_cs_n && $stable(mem_addr) &&
                   $stable(mem_dout) && $stable({mem_ub_n, mem_lb_n})));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int ACC  = (55 + 20 - 1) / 20;
  localparam int TURN = 1;
  localparam int REC  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        busy;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
  logic [17:0] mem_addr;
  logic [15:0] mem_dout;
  logic        mem_dout_en;
  logic [15:0] mem_din;

  int checks = 0;
  int errors = 0;
  logic model_on = 1'b0;
  logic [15:0] ram   [0:255];
  logic [15:0] shadow[0:255];

  always #10 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  // Behavioural RAM: drives only on read, undriven lanes show a float pattern.
  always_comb begin
    mem_din = 16'hEEEE;
    if (model_on && !mem_cs_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_din[7:0]  = ram[mem_addr[7:0]][7:0];
      if (!mem_ub_n) mem_din[15:8] = ram[mem_addr[7:0]][15:8];
    end
  end

  always @(posedge mem_we_n) begin
    if (model_on && !mem_cs_n) begin
      if (!mem_dout_en) begin
        errors++;
        $display("FAIL R7 data not driven at write edge actual %0d expected 1", mem_dout_en);
      end
      if (!mem_lb_n) ram[mem_addr[7:0]][7:0]  = mem_dout[7:0];
      if (!mem_ub_n) ram[mem_addr[7:0]][15:8] = mem_dout[15:8];
    end
  end

  always @(negedge clk) begin
    if (model_on && !mem_cs_n && !mem_oe_n && mem_we_n && mem_dout_en) begin
      errors++;
      $display("FAIL R6 bus contention actual dout_en=1 expected 0");
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int n = 1;
    int we_lo = 0;
    issue(1'b1, a, d, m);
    chk(!mem_dout_en && mem_oe_n && !mem_cs_n, "R6 turnaround", {mem_dout_en, mem_oe_n, mem_cs_n}, 3'b010);
    chk({mem_ub_n, mem_lb_n} == ~m, "R3 write lanes", {mem_ub_n, mem_lb_n}, ~m);
    while (busy && n < 50) begin
      if (!mem_we_n) we_lo++;
      @(negedge clk);
      n++;
    end
    chk(we_lo == ACC, "R7 we width", we_lo, ACC);
    chk(n == TURN + ACC + REC + 1, "R7 write length", n, TURN + ACC + REC + 1);
    chk(req_ready && mem_cs_n, "R8 ready after write", {req_ready, mem_cs_n}, 2'b11);
    if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] m);
    int n = 1;
    logic [15:0] exp;
    exp = {m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00};
    issue(1'b0, a, 16'h0, m);
    chk(mem_addr == a && busy, "R2 address/busy", {busy, 13'h0, mem_addr}, {1'b1, 13'h0, a});
    chk(!mem_oe_n && mem_we_n && !mem_cs_n, "R4 read strobes", {mem_oe_n, mem_we_n, mem_cs_n}, 3'b010);
    chk({mem_ub_n, mem_lb_n} == ~m, "R3 read lanes", {mem_ub_n, mem_lb_n}, ~m);
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == ACC + 1, "R5 read latency", n, ACC + 1);
    chk(rsp_rdata == exp, "R4 read data", rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R5 single pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
      shadow[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    // R1: standby after reset
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dout_en,
        "R1 reset strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dout_en}, 6'b111110);
    chk(!busy && req_ready && !rsp_valid, "R1 reset status", {busy, req_ready, rsp_valid}, 3'b010);

    // Baseline reads of untouched words
    for (int a = 0; a < 4; a++) do_read(18'(a), 2'b11);

    // R3/R7/R8 sweep: every lane mask over a set of addresses, read back at once
    for (int a = 0; a < 32; a++) begin
      for (int m = 1; m < 4; m++) begin
        do_write(18'(a * 7), 16'((a * 37 + m * 101) ^ 16'hC3A5), 2'(m));
        do_read(18'(a * 7), 2'b11);
        do_read(18'(a * 7), 2'(m));
      end
    end

    // High address end of the range (model aliases on low bits)
    do_write(18'h3FFFF, 16'hBEEF, 2'b11);
    do_read(18'h3FFFF, 2'b11);

    // R3: empty mask write is dropped
    issue(1'b1, 18'd5, 16'hFFFF, 2'b00);
    for (int k = 0; k < 6; k++) begin
      chk(mem_cs_n && mem_we_n && !busy && !rsp_valid, "R3 empty mask write",
          {mem_cs_n, mem_we_n, busy, rsp_valid}, 4'b1100);
      @(negedge clk);
    end
    do_read(18'd5, 2'b11);

    // R3: empty mask read gives no response
    issue(1'b0, 18'd9, 16'h0, 2'b00);
    for (int k = 0; k < 6; k++) begin
      chk(mem_cs_n && mem_oe_n && !busy && !rsp_valid, "R3 empty mask read",
          {mem_cs_n, mem_oe_n, busy, rsp_valid}, 4'b1100);
      @(negedge clk);
    end

    chk(mem_cs_n && !busy, "R1 idle at end", {mem_cs_n, busy}, 2'b10);
    finish_run();
  end

endmodule